// File: doc/BRIEF.md
# Grouped 64-Port Switch with Double-Buffered Routing Store

This block routes 64 single-bit lanes through eight independent 8x8 switching elements. Lanes are split into groups of eight. Each of the 64 outputs picks one of the eight inputs of its own group, through a three-level tree of 2-to-1 multiplexers steered by a 3-bit select code. The 64 codes together form a 192-bit routing configuration.

The configuration is held twice. A load-side copy is filled over a narrow 12-bit write port, one word per cycle, with a 4-bit word address. Sixteen writes fill it completely, and any subset of words may be rewritten. The active copy steers the multiplexers. A one-cycle commit strobe moves the whole load-side copy into the active copy in a single step, so routing never shows a half-loaded configuration. A test input bypasses routing and drives the low 64 bits of the active copy onto the outputs. Software can then toggle output lanes by rewriting and committing configuration words.

Top module: `xbar64_staged`

## Requirements
- R1: After reset, both configuration copies hold the identity code (output j of each group selects input j of that group), so dataOut equals dataIn in normal mode.
- R2: Output lane o = 8e+j takes its 3-bit code s from active bits [3o+2:3o] and carries input lane 8e+s. Code bit 0 steers the first multiplexer level, bit 1 the second and bit 2 the third.
- R3: No output lane is ever driven from an input lane outside its own group of eight.
- R4: A cycle with wrEn high writes wrData into load-side bits [12k+11:12k], where k is wrAddr. All other load-side bits keep their value.
- R5: Writes to the load-side copy have no effect on the outputs until a commit.
- R6: A commit pulse copies all 192 load-side bits into the active copy at that clock edge. The new routing appears from the next cycle on.
- R7: When a write and a commit fall in the same cycle, the active copy takes the load-side contents from before that write. The written word stays in the load-side copy for a later commit.
- R8: With testMode high, dataOut[n] equals active bit n for n in 0..63, and dataIn has no effect.
- R9: A commit with no intervening writes leaves the active copy, and so the routing, unchanged.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load-side word write enable |
| wrAddr | input | 4 | Load-side word index |
| wrData | input | 12 | Load-side word value |
| commit | input | 1 | Copy load-side store into active store |
| testMode | input | 1 | Drive outputs from active store bits |
| dataIn | input | 64 | Input lanes |
| dataOut | output | 64 | Output lanes |

## Verification
The bench walks a single one across all 64 inputs under several committed configurations. A wrong level-to-bit order or a swapped leaf would move that one to the wrong lane, and a leak across groups would light a lane in a foreign group. It also fills the load-side copy fully and checks that the outputs do not move before the commit, which would catch a design that routes straight from the load-side store. It then writes and commits in the same cycle, which would expose a design whose commit copies the freshly written word. A partial rewrite of one word shows whether a write spills into neighbouring words. A repeated commit shows whether the load-side copy is lost after a transfer.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned GROUPS   = 8;
  localparam int unsigned WAYS     = 8;
  localparam int unsigned SEL_W    = $clog2(WAYS);
  localparam int unsigned PORTS    = GROUPS * WAYS;
  localparam int unsigned CFG_BITS = PORTS * SEL_W;
  localparam int unsigned BUS_W    = 12;
  localparam int unsigned WORDS    = CFG_BITS / BUS_W;
  localparam int unsigned ADDR_W   = $clog2(WORDS);

  typedef struct packed {
    logic [WORDS-1:0] wordWe;
    logic             commit;
  } cfg_strobe_t;

  function automatic logic [CFG_BITS-1:0] identityCfg();
    logic [CFG_BITS-1:0] cfg;
    cfg = '0;
    for (int o = 0; o < PORTS; o++) cfg[o*SEL_W +: SEL_W] = SEL_W'(o % WAYS);
    return cfg;
  endfunction
endpackage

// File: rtl/xbar_mux_tree.sv
module xbar_mux_tree #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned SEL_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  leafIn,
  input  logic [SEL_W-1:0] sel,
  output logic             rootOut
);
  localparam int unsigned NODES = 2 * WAYS - 1;
  logic [NODES-1:0] node;

  genvar d, i;
  generate
    for (i = 0; i < WAYS; i++) begin : g_leaf
      assign node[WAYS-1+i] = leafIn[i];
    end
    // depth 0 is the root, steered by the top select bit; leaves level uses bit 0
    for (d = 0; d < SEL_W; d++) begin : g_depth
      for (i = 0; i < (1 << d); i++) begin : g_node
        localparam int unsigned N = (1 << d) - 1 + i;
        assign node[N] = sel[SEL_W-1-d] ? node[2*N+2] : node[2*N+1];
      end
    end
  endgenerate

  assign rootOut = node[0];
endmodule

// File: rtl/xbar_ctrl.sv
module xbar_ctrl
  import xbar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              commit,
  output cfg_strobe_t       strb
);
  always_comb begin
    strb.wordWe = '0;
    if (wrEn) strb.wordWe[wrAddr] = 1'b1;
    strb.commit = commit;
  end

  // R4
  word_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ($countones(strb.wordWe) == 1 && strb.wordWe[wrAddr]));

  // R4
  idle_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strb.wordWe == '0));
endmodule

// File: rtl/xbar_datapath.sv
module xbar_datapath
  import xbar_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cfg_strobe_t      strb,
  input  logic [BUS_W-1:0] wrData,
  input  logic             testMode,
  input  logic [PORTS-1:0] dataIn,
  output logic [PORTS-1:0] dataOut
);
  logic [CFG_BITS-1:0] cacheQ;
  logic [CFG_BITS-1:0] mapQ;
  logic [PORTS-1:0]    routed;

  genvar k, o;
  generate
    for (k = 0; k < WORDS; k++) begin : g_word
      localparam logic [CFG_BITS-1:0] RST_CFG = identityCfg();
      always_ff @(posedge clk) begin
        if (!rstN)                cacheQ[k*BUS_W +: BUS_W] <= RST_CFG[k*BUS_W +: BUS_W];
        else if (strb.wordWe[k]) cacheQ[k*BUS_W +: BUS_W] <= wrData;
      end

      // R4
      cache_write_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.wordWe[k] |=> cacheQ[k*BUS_W +: BUS_W] == $past(wrData));

      // R4
      cache_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strb.wordWe[k] |=> $stable(cacheQ[k*BUS_W +: BUS_W]));
    end

    for (o = 0; o < PORTS; o++) begin : g_port
      localparam int unsigned GRP = o / WAYS;
      xbar_mux_tree #(.WAYS(WAYS), .SEL_W(SEL_W)) u_tree (
        .leafIn (dataIn[GRP*WAYS +: WAYS]),
        .sel    (mapQ[o*SEL_W +: SEL_W]),
        .rootOut(routed[o])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            mapQ <= identityCfg();
    else if (strb.commit) mapQ <= cacheQ;
  end

  assign dataOut = testMode ? mapQ[PORTS-1:0] : routed;

  // R5
  map_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(mapQ));

  // R6 R7
  map_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> mapQ == $past(cacheQ));

  // R8
  test_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && $stable(mapQ) && $past(testMode)) |-> $stable(dataOut));
endmodule

// File: rtl/xbar64_staged.sv
module xbar64_staged
  import xbar_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              commit,
  input  logic              testMode,
  input  logic [PORTS-1:0]  dataIn,
  output logic [PORTS-1:0]  dataOut
);
  cfg_strobe_t strb;

  xbar_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .commit(commit),
    .strb  (strb)
  );

  xbar_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .testMode(testMode),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );
endmodule

// File: tb/xbar64_staged_bench.sv
`timescale 1ns/1ps
module xbar64_staged_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [11:0] wrData = '0;
  logic        commit = 1'b0;
  logic        testMode = 1'b0;
  logic [63:0] dataIn = '0;
  logic [63:0] dataOut;

  int checks = 0;
  int errors = 0;
  logic [191:0] cacheM;
  logic [191:0] mapM;

  always #5 clk = ~clk;

  xbar64_staged u_xbar64_staged (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .commit(commit), .testMode(testMode), .dataIn(dataIn), .dataOut(dataOut)
  );

  function automatic logic [191:0] identityM();
    logic [191:0] c;
    for (int o = 0; o < 64; o++) c[3*o +: 3] = 3'(o % 8);
    return c;
  endfunction

  function automatic logic [191:0] genCfg(int seed);
    logic [191:0] c;
    for (int o = 0; o < 64; o++) c[3*o +: 3] = 3'((o * seed + seed / 2 + o / 8) % 8);
    return c;
  endfunction

  function automatic logic [63:0] expRoute(logic [191:0] m, logic [63:0] din);
    logic [63:0] r;
    for (int o = 0; o < 64; o++) r[o] = din[(o / 8) * 8 + int'(m[3*o +: 3])];
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] din);
    @(negedge clk);
    dataIn = din;
    #1;
  endtask

  task automatic writeWord(int k, logic [11:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'(k); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    cacheM[12*k +: 12] = d;
  endtask

  task automatic doCommit();
    @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    mapM = cacheM;
  endtask

  // walking one over every input plus two dense patterns; R2 and R3
  task automatic routeSweep(string tag);
    for (int i = 0; i < 64; i++) begin
      drive(64'd1 << i);
      check(tag, dataOut, expRoute(mapM, dataIn));
    end
    drive(64'hA5C3_0F96_5A3C_F069);
    check(tag, dataOut, expRoute(mapM, dataIn));
    drive(64'hFFFF_0000_1234_8765);
    check(tag, dataOut, expRoute(mapM, dataIn));
  endtask

  task automatic t_reset();
    cacheM = identityM();
    mapM = identityM();
    drive(64'h0123_4567_89AB_CDEF);
    check("R1 identity after reset", dataOut, dataIn);
    drive(64'hFEDC_BA98_7654_3210);
    check("R1 identity after reset", dataOut, dataIn);
    testMode = 1'b1;
    drive(64'h0);
    check("R1 R8 reset map bits", dataOut, identityM() >> 0);
    testMode = 1'b0;
  endtask

  task automatic t_loadNoEffect();
    logic [191:0] cfg;
    cfg = genCfg(5);
    for (int k = 0; k < 16; k++) writeWord(k, cfg[12*k +: 12]);
    drive(64'h0F1E_2D3C_4B5A_6978);
    check("R5 no change before commit", dataOut, dataIn);
    testMode = 1'b1;
    drive(64'h0);
    check("R5 map untouched before commit", dataOut, identityM() >> 0);
    testMode = 1'b0;
  endtask

  task automatic t_commitRoute();
    doCommit();
    routeSweep("R6 R2 R3 committed routing");
    testMode = 1'b1;
    drive(64'h0);
    check("R6 map after commit", dataOut, mapM[63:0]);
    testMode = 1'b0;
  endtask

  task automatic t_partialWrite();
    writeWord(5, 12'hB6D);
    doCommit();
    testMode = 1'b1;
    drive(64'h0);
    check("R4 single word rewrite", dataOut, mapM[63:0]);
    testMode = 1'b0;
    routeSweep("R4 routing after word rewrite");
  endtask

  task automatic t_concurrent();
    logic [191:0] preMap;
    preMap = cacheM;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd0; wrData = 12'h5A7; commit = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; commit = 1'b0;
    mapM = preMap;
    cacheM[11:0] = 12'h5A7;
    testMode = 1'b1;
    drive(64'h0);
    check("R7 commit takes pre-write cache", dataOut, mapM[63:0]);
    testMode = 1'b0;
    drive(64'h00FF_00FF_1248_8421);
    check("R7 routing uses old word", dataOut, expRoute(mapM, dataIn));
    doCommit();
    testMode = 1'b1;
    drive(64'h0);
    check("R7 later commit picks up write", dataOut, mapM[63:0]);
    testMode = 1'b0;
  endtask

  task automatic t_testMode();
    logic [191:0] cfg;
    cfg = genCfg(3);
    for (int k = 0; k < 16; k++) writeWord(k, cfg[12*k +: 12]);
    doCommit();
    testMode = 1'b1;
    drive(64'hFFFF_FFFF_FFFF_FFFF);
    check("R8 test mode ignores inputs", dataOut, mapM[63:0]);
    drive(64'h1357_9BDF_0246_8ACE);
    check("R8 test mode ignores inputs", dataOut, mapM[63:0]);
    writeWord(2, ~cacheM[35:24]);
    doCommit();
    check("R8 test mode toggles with config", dataOut, mapM[63:0]);
    testMode = 1'b0;
    routeSweep("R8 routing restored");
  endtask

  task automatic t_recommit();
    logic [191:0] keep;
    keep = mapM;
    doCommit();
    testMode = 1'b1;
    drive(64'h0);
    check("R9 repeat commit keeps map", dataOut, keep[63:0]);
    testMode = 1'b0;
    drive(64'h8000_0001_4000_0002);
    check("R9 repeat commit keeps routing", dataOut, expRoute(keep, dataIn));
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_loadNoEffect();
    t_commitRoute();
    t_partialWrite();
    t_concurrent();
    t_testMode();
    t_recommit();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule